// File: doc/BRIEF.md
# Double-Data-Rate Serial-to-Parallel Receiver

This block turns per-channel serial data, delivered two bits per fast edge-clock cycle by a double-data-rate input cell, into parallel words in a slow parallel-clock domain. Each channel runs through four register stages. An input capture stage samples the bit pair on the edge clock. An accumulator gathers the bits. A hold register in the edge domain receives a word each time enough bits have arrived. A parallel register on the slow clock then takes over that word. The first bit received in time lands in the least significant position.

The word width (factor) and the channel count are parameters. The edge clock runs at factor/2 times the slow clock and is frequency-locked to it, so the slow clock sees one new hold-register value per period. With an odd factor, the word boundary falls alternately between the two bits of a pair and at the end of a pair. A per-channel slip pulse moves that channel's word boundary one bit later, which lets a controller rotate the received word until it matches a known training pattern. A shared valid flag reports when every channel has delivered its first word.

Top module: `ddr_deser_rx`

## Requirements
- R1: While reset is low, `pdata` is all zeros and `pvalid` is low. Both take these values as soon as reset falls, without waiting for a clock edge.
- R2: In each channel's input pair, bit 0 is the earlier bit in time and bit 1 is the later bit.
- R3: The earliest received bit of a word appears at bit 0 of that channel's slice of `pdata`. The latest appears at bit FACTOR-1. Channel c occupies `pdata[c*FACTOR +: FACTOR]`.
- R4: Words are made of consecutive bits. When no slip occurs, no bit is dropped or used twice, so a serial stream that repeats a word W yields W, or a fixed rotation of W, on every slow cycle.
- R5: For an odd factor, the word boundary alternates between the middle and the end of an edge-clock cycle, so every slow-clock cycle carries one complete and correct word.
- R6: Each one-edge-cycle slip pulse drops one bit, which moves the boundary one bit later. For a repeated word W, the result rotates right by one: {W[0], W[FACTOR-1:1]}. FACTOR pulses restore the original alignment.
- R7: A slip on one channel leaves the word alignment of every other channel unchanged.
- R8: The edge-domain hold register keeps its value between word loads, so `pdata` stays constant while the serial input repeats one aligned word.
- R9: `pvalid` stays low after reset until every channel has loaded its first word, then stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| eclk | input | 1 | Fast edge clock, FACTOR/2 times `sclk` |
| sclk | input | 1 | Slow parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| din | input | 2*NCH | Two bits per channel per edge cycle; bit 2c is earlier than bit 2c+1 |
| slip | input | NCH | Per-channel one-edge-cycle pulse that delays the word boundary by one bit |
| pdata | output | NCH*FACTOR | Parallel words, channel c at bits c*FACTOR and up |
| pvalid | output | 1 | High once every channel has delivered a word after reset |

## Verification
The hardest case to reach from the ports is the odd-factor boundary pattern. With the default factor of 7, every second word is split across an edge-clock cycle. The serial source and this block share no word phase, so the starting boundary is unknown. The bench generates an edge clock at exactly 3.5 times the slow clock from integer edge times. It streams each channel's word continuously and applies slip pulses until a non-symmetric training word appears, which fixes the boundary. After that, constant words are checked over several consecutive slow cycles, so both the split and the unsplit boundaries are observed. Single-bit words and slip rotations then expose any error in bit order or boundary movement.

// File: rtl/ddr_rx_pkg.sv
`timescale 1ps/1ps
package ddr_rx_pkg;
  // bits delivered by the input cell on every edge-clock cycle
  localparam int unsigned BITS_PER_ECLK = 2;
  // largest channel count the block is dimensioned for
  localparam int unsigned MAX_LANES = 15;

  function automatic bit factor_supported(input int unsigned f);
    return (f == 2) || (f == 4) || (f == 7) || (f == 8);
  endfunction
endpackage

// File: rtl/rx_rst_sync.sv
`timescale 1ps/1ps
module rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/ddr_deser_lane.sv
`timescale 1ps/1ps
module ddr_deser_lane
  import ddr_rx_pkg::*;
#(
  parameter int unsigned FACTOR = 7
) (
  input  logic                     eclk,
  input  logic                     erst_n,
  input  logic [BITS_PER_ECLK-1:0] din,
  input  logic                     slip,
  output logic [FACTOR-1:0]        word_o,
  output logic                     loaded_o
);
  localparam int unsigned ACCW = BITS_PER_ECLK * FACTOR;
  localparam int unsigned CW   = $clog2(ACCW + 1);

  // stage 1: input capture, stage 2: accumulator, stage 3: hold register
  logic [BITS_PER_ECLK-1:0] in_q;
  logic [ACCW-1:0]          acc, acc_nx;
  logic [CW-1:0]            cnt, cnt_nx, avail, base;
  logic [FACTOR-1:0]        upd, word_nx;
  logic                     loaded, take;

  always_comb begin
    // newest pair enters at the top, older bits move toward bit 0
    acc_nx  = {in_q, acc[ACCW-1:BITS_PER_ECLK]};
    // a slip drops the oldest incoming bit, so only one new bit counts
    avail   = cnt + (slip ? CW'(1) : CW'(BITS_PER_ECLK));
    take    = (avail >= CW'(FACTOR));
    base    = CW'(ACCW) - avail;
    word_nx = acc_nx[base +: FACTOR];
    cnt_nx  = take ? (avail - CW'(FACTOR)) : avail;
  end

  always_ff @(posedge eclk or negedge erst_n) begin
    if (!erst_n) begin
      in_q   <= '0;
      acc    <= '0;
      cnt    <= '0;
      upd    <= '0;
      loaded <= 1'b0;
    end else begin
      in_q <= din;
      acc  <= acc_nx;
      cnt  <= cnt_nx;
      if (take) begin
        upd    <= word_nx;
        loaded <= 1'b1;
      end
    end
  end

  assign word_o   = upd;
  assign loaded_o = loaded;

  // R4
  cnt_range_chk: assert property (@(posedge eclk) disable iff (!erst_n)
    cnt < CW'(FACTOR));

  // R8
  upd_hold_chk: assert property (@(posedge eclk) disable iff (!erst_n)
    !take |=> $stable(upd));

  // R9
  loaded_sticky_chk: assert property (@(posedge eclk) disable iff (!erst_n)
    loaded |=> loaded);

  generate
    if (FACTOR >= 4) begin : g_spacing
      // R5
      load_spacing_chk: assert property (@(posedge eclk) disable iff (!erst_n)
        take |=> !take);
    end
  endgenerate
endmodule

// File: rtl/ddr_deser_rx.sv
`timescale 1ps/1ps
module ddr_deser_rx
  import ddr_rx_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned FACTOR = 7
) (
  input  logic                          eclk,
  input  logic                          sclk,
  input  logic                          rst_n,
  input  logic [BITS_PER_ECLK*NCH-1:0]  din,
  input  logic [NCH-1:0]                slip,
  output logic [NCH*FACTOR-1:0]         pdata,
  output logic                          pvalid
);
  localparam int unsigned WTOT = NCH * FACTOR;

  logic            erst_n, srst_n;
  logic [WTOT-1:0] upd_all;
  logic [NCH-1:0]  loaded_v;
  logic            all_loaded;
  logic [WTOT-1:0] pdata_q;
  logic            pvalid_q;

  rx_rst_sync #(.STAGES(2)) u_ersync (.clk(eclk), .arst_n(rst_n), .srst_n(erst_n));
  rx_rst_sync #(.STAGES(2)) u_srsync (.clk(sclk), .arst_n(rst_n), .srst_n(srst_n));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_lane
      ddr_deser_lane #(.FACTOR(FACTOR)) u_lane (
        .eclk     (eclk),
        .erst_n   (erst_n),
        .din      (din[g*BITS_PER_ECLK +: BITS_PER_ECLK]),
        .slip     (slip[g]),
        .word_o   (upd_all[g*FACTOR +: FACTOR]),
        .loaded_o (loaded_v[g])
      );
    end
  endgenerate

  assign all_loaded = &loaded_v;

  // stage 4: parallel register on the slow clock, frequency-locked to eclk
  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      pdata_q  <= '0;
      pvalid_q <= 1'b0;
    end else begin
      pdata_q  <= upd_all;
      pvalid_q <= all_loaded;
    end
  end

  assign pdata  = pdata_q;
  assign pvalid = pvalid_q;

  // R9
  valid_sticky_chk: assert property (@(posedge sclk) disable iff (!srst_n)
    pvalid |=> pvalid);

  // R9
  valid_cause_chk: assert property (@(posedge sclk) disable iff (!srst_n)
    $rose(pvalid) |-> $past(all_loaded));
endmodule

// File: tb/tb_ddr_deser_rx.sv
`timescale 1ps/1ps
module tb_ddr_deser_rx;
  localparam int unsigned NCH    = 2;
  localparam int unsigned FACTOR = 7;
  localparam longint      SCLK_PS = 20000;   // 50 MHz slow clock
  localparam logic [6:0]  TRAIN   = 7'b0010111;
  localparam int unsigned NVEC    = 8;
  // each entry: {channel 1 word, channel 0 word}
  localparam logic [13:0] VEC [NVEC] = '{
    {7'h40, 7'h01}, {7'h01, 7'h40}, {7'h2a, 7'h55}, {7'h7f, 7'h00},
    {7'h00, 7'h7f}, {7'h33, 7'h0f}, {7'h0e, 7'h71}, {7'h5b, 7'h24}
  };

  logic                   eclk, sclk, rst_n;
  logic [2*NCH-1:0]       din;
  logic [NCH-1:0]         slip;
  logic [NCH*FACTOR-1:0]  pdata;
  logic                   pvalid;

  int checks, errors;
  logic [6:0] wd [NCH];
  bit done;

  ddr_deser_rx #(.NCH(NCH), .FACTOR(FACTOR)) dut (
    .eclk(eclk), .sclk(sclk), .rst_n(rst_n), .din(din), .slip(slip),
    .pdata(pdata), .pvalid(pvalid)
  );

  initial begin
    sclk = 1'b0;
    forever begin
      #(SCLK_PS/2) sclk = ~sclk;
    end
  end

  // edge clock at exactly FACTOR/2 times sclk, from integer edge times
  initial begin
    longint prev;
    prev = 0;
    eclk = 1'b0;
    for (longint k = 1; ; k++) begin
      longint t;
      t = (k * SCLK_PS) / FACTOR;
      #(t - prev);
      prev = t;
      eclk = ~eclk;
    end
  end

  // serial source: each channel repeats its word, earliest bit in din[2c]
  initial begin
    int n;
    n = 0;
    din = '0;
    forever begin
      @(negedge eclk);
      for (int c = 0; c < NCH; c++) begin
        din[2*c]   = wd[c][n % FACTOR];
        din[2*c+1] = wd[c][(n + 1) % FACTOR];
      end
      n = (n + 2) % FACTOR;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_s(input int n);
    for (int i = 0; i < n; i++) @(negedge sclk);
  endtask

  task automatic pulse_slip(input int c);
    @(negedge eclk);
    slip[c] = 1'b1;
    @(negedge eclk);
    slip[c] = 1'b0;
  endtask

  function automatic logic [6:0] lane(input logic [NCH*FACTOR-1:0] p, input int c);
    return p[c*FACTOR +: FACTOR];
  endfunction

  function automatic logic [6:0] ror1(input logic [6:0] w);
    return {w[0], w[6:1]};
  endfunction

  initial begin
    #(SCLK_PS * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] ch1_before;
    bit hit;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    slip  = '0;
    wd[0] = 7'h15; wd[1] = 7'h6a;
    wait_s(5);
    // R1 reset state
    chk("R1 pdata in reset", 32'(pdata), 32'h0);
    chk("R1 pvalid in reset", 32'(pvalid), 32'h0);
    rst_n = 1'b1;
    wait_s(1);
    // R9 not valid straight after release
    chk("R9 pvalid before first word", 32'(pvalid), 32'h0);

    wd[0] = TRAIN; wd[1] = TRAIN;
    wait_s(10);
    chk("R9 pvalid after first word", 32'(pvalid), 32'h1);

    // align channel 0 by slipping (R6); channel 1 must not move (R7)
    ch1_before = lane(pdata, 1);
    hit = 0;
    for (int i = 0; i < FACTOR && !hit; i++) begin
      if (lane(pdata, 0) == TRAIN) hit = 1;
      else begin pulse_slip(0); wait_s(6); end
    end
    chk("R6 ch0 aligns to training word", 32'(lane(pdata, 0)), 32'(TRAIN));
    chk("R7 ch1 unchanged by ch0 slips", 32'(lane(pdata, 1)), 32'(ch1_before));
    hit = 0;
    for (int i = 0; i < FACTOR && !hit; i++) begin
      if (lane(pdata, 1) == TRAIN) hit = 1;
      else begin pulse_slip(1); wait_s(6); end
    end
    chk("R6 ch1 aligns to training word", 32'(lane(pdata, 1)), 32'(TRAIN));
    chk("R7 ch0 unchanged by ch1 slips", 32'(lane(pdata, 0)), 32'(TRAIN));

    // table of words: R2 R3 R4 R5, with hold across cycles R8
    for (int v = 0; v < NVEC; v++) begin
      wd[0] = VEC[v][6:0];
      wd[1] = VEC[v][13:7];
      wait_s(8);
      chk("R3 R2 word ch0", 32'(lane(pdata, 0)), 32'(VEC[v][6:0]));
      chk("R3 R2 word ch1", 32'(lane(pdata, 1)), 32'(VEC[v][13:7]));
      for (int s = 0; s < 3; s++) begin
        wait_s(1);
        chk("R5 R8 word stable", 32'(pdata), 32'(VEC[v]));
      end
    end
    chk("R9 pvalid stays high", 32'(pvalid), 32'h1);

    // slip rotation on a single-bit word (R6)
    wd[0] = 7'h01; wd[1] = 7'h2a;
    wait_s(8);
    pulse_slip(0);
    wait_s(6);
    chk("R6 one slip rotates right", 32'(lane(pdata, 0)), 32'(ror1(7'h01)));
    chk("R7 ch1 kept during rotation", 32'(lane(pdata, 1)), 32'h2a);
    for (int i = 1; i < FACTOR; i++) begin
      pulse_slip(0);
      wait_s(3);
    end
    wait_s(4);
    chk("R6 full slip cycle restores word", 32'(lane(pdata, 0)), 32'h01);

    // reset mid-run takes effect without a clock edge (R1)
    @(negedge sclk);
    #(SCLK_PS/8);
    rst_n = 1'b0;
    #(SCLK_PS/8);
    chk("R1 pdata cleared asynchronously", 32'(pdata), 32'h0);
    chk("R1 pvalid cleared asynchronously", 32'(pvalid), 32'h0);
    wait_s(2);
    rst_n = 1'b1;
    wait_s(1);
    chk("R9 pvalid low after second reset", 32'(pvalid), 32'h0);
    wait_s(10);
    chk("R9 pvalid returns", 32'(pvalid), 32'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule